// File: doc/BRIEF.md
# Master-Clock-to-Sample-Rate Ratio Detector

This block works out how many master-clock cycles make up one audio sample period. The frame-sync signal is asynchronous to the master clock. It is resynchronised into the master-clock domain, and the block counts the cycles between its consecutive rising edges. Each measured period is compared against six supported oversampling ratios, with a symmetric tolerance window around each one. The result is a small ratio code that downstream filter and noise-shaping logic uses to select its operating mode.

When a measured period falls outside every window, the block raises both a mute output and a converter-shutdown output. It also raises both when frame sync stops rising for longer than the largest window allows. Mute is only released after two consecutive periods agree on the same ratio. This keeps phase wander and jitter on the frame sync from making the outputs chatter. While mute is asserted, the ratio output holds its last confirmed value.

Top module: `mclk_ratio_detect`

## Requirements
- R1: Out of reset, mute and shutdown are both 1 and the ratio code is 0. The first frame-sync rising edge after reset only starts a measurement and produces no classification.
- R2: A period of P cycles matches a nominal N when N-32 <= P <= N+32. Valid periods set the ratio code as follows: 128→0, 192→1, 256→2, 384→3, 512→4, 768→5. So 96 and 160 give 0, 800 gives 5, and 736 gives 5.
- R3: When a period lies in two windows at once, the lower ratio wins. A period of 160 gives code 0 and a period of 224 gives code 1.
- R4: A period that matches no window sets mute=1 and shutdown=1 and leaves the ratio code unchanged. Examples are 95, 289, 735 and 60.
- R5: Mute and shutdown are released only when two consecutive measured periods classify to the same code. The ratio code takes that code at the same moment. Periods that vary within one window count as the same code.
- R6: While unmuted, a period that classifies to a different code sets mute=1 and leaves shutdown=0 and the ratio code unchanged. Two consecutive periods of one code then release mute with that code.
- R7: If no frame-sync rising edge arrives within 801 cycles of the previous one, mute and shutdown are set before the next edge arrives. That next edge only restarts measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Frame sync, asynchronous to clk |
| mute_o | output | 1 | Output mute request |
| shutdown_o | output | 1 | Converter shutdown request |
| ratio_o | output | 3 | Detected ratio code, 0..5 in ascending ratio order |

## Verification
The hardest situations to reach from the ports are a period that lands exactly on a window edge and a period that lands in an overlap between two windows. Another is a single stray period while locked, which must mute the output without shutting the converter down. The bench drives frame-sync waveforms with exact cycle lengths. It places directed frames at 95, 96, 160, 224, 289, 352, 735, 736 and 800 cycles, and at a lone 512 between runs of 384. It then adds seeded random runs of jittered frames and occasional garbage lengths, and checks every frame against a bench model of the lock rules. Overrun is reached by holding the frame sync for 900 cycles and sampling the outputs before the late edge arrives.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

  // Nominal cycle count for ratio index i: base, 1.5*base, 2*base, 3*base, ...
  function automatic int nominal_count(input int base, input int idx);
    int r;
    if ((idx % 2) == 0) r = base << (idx / 2);
    else                r = ((base * 3) / 2) << (idx / 2);
    return r;
  endfunction

  function automatic int max_nominal(input int base, input int n);
    return nominal_count(base, n - 1);
  endfunction

endpackage

// File: rtl/fsync_sync.sv
module fsync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W   = 10,
  parameter int SAT_VAL = 801
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  output logic             meas_vld_o,
  output logic             meas_ovf_o,
  output logic [CNT_W-1:0] meas_val_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             armed_q;

  assign cnt_inc = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_vld_o <= 1'b0;
      meas_ovf_o <= 1'b0;
      meas_val_o <= '0;
    end else begin
      meas_vld_o <= 1'b0;
      meas_ovf_o <= 1'b0;
      if (edge_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          meas_vld_o <= 1'b1;
          meas_val_o <= cnt_inc;
        end
      end else begin
        cnt_q <= cnt_inc;
        if (armed_q && (cnt_inc == SAT)) begin
          meas_vld_o <= 1'b1;
          meas_ovf_o <= 1'b1;
          meas_val_o <= cnt_inc;
          armed_q    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import mclk_ratio_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int CODE_W     = 3,
  parameter int NUM_RATIOS = 6,
  parameter int BASE       = 128,
  parameter int TOL        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_vld_i,
  input  logic              meas_ovf_i,
  input  logic [CNT_W-1:0]  meas_val_i,
  output logic              cls_vld_o,
  output logic              cls_ok_o,
  output logic [CODE_W-1:0] cls_code_o
);
  logic [NUM_RATIOS-1:0] hit;
  logic [CODE_W-1:0]     pick;

  for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_win
    localparam int NOM = nominal_count(BASE, k);
    localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
    assign hit[k] = (meas_val_i >= LO) && (meas_val_i <= HI);
  end

  // lowest matching ratio has priority
  always_comb begin
    pick = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) pick = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_vld_o  <= 1'b0;
      cls_ok_o   <= 1'b0;
      cls_code_o <= '0;
    end else begin
      cls_vld_o <= meas_vld_i;
      if (meas_vld_i) begin
        cls_ok_o   <= ~meas_ovf_i && (|hit);
        cls_code_o <= pick;
      end
    end
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cls_vld_i,
  input  logic              cls_ok_i,
  input  logic [CODE_W-1:0] cls_code_i,
  output logic              mute_o,
  output logic              shutdown_o,
  output logic [CODE_W-1:0] ratio_o
);
  logic [CODE_W-1:0] cand_q;
  logic              streak_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_o     <= 1'b1;
      shutdown_o <= 1'b1;
      ratio_o    <= '0;
      cand_q     <= '0;
      streak_q   <= 1'b0;
    end else if (cls_vld_i) begin
      if (!cls_ok_i) begin
        mute_o     <= 1'b1;
        shutdown_o <= 1'b1;
        streak_q   <= 1'b0;
      end else if (streak_q && (cls_code_i == cand_q)) begin
        mute_o     <= 1'b0;
        shutdown_o <= 1'b0;
        ratio_o    <= cls_code_i;
      end else begin
        mute_o   <= 1'b1;
        cand_q   <= cls_code_i;
        streak_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mclk_ratio_pkg::*;
#(
  parameter int BASE        = 128,
  parameter int NUM_RATIOS  = 6,
  parameter int TOL         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fsync_in,
  output logic       mute_o,
  output logic       shutdown_o,
  output logic [2:0] ratio_o
);
  localparam int CODE_W  = (NUM_RATIOS > 1) ? $clog2(NUM_RATIOS) : 1;
  localparam int SAT_VAL = max_nominal(BASE, NUM_RATIOS) + TOL + 1;
  localparam int CNT_W   = $clog2(SAT_VAL + 1);

  logic              fs_rise;
  logic              meas_vld, meas_ovf;
  logic [CNT_W-1:0]  meas_val;
  logic              cls_vld, cls_ok;
  logic [CODE_W-1:0] cls_code;
  logic [CODE_W-1:0] ratio_int;

  fsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(fsync_in), .rise_o(fs_rise)
  );

  period_counter #(.CNT_W(CNT_W), .SAT_VAL(SAT_VAL)) u_cnt (
    .clk(clk), .rst(rst), .edge_i(fs_rise),
    .meas_vld_o(meas_vld), .meas_ovf_o(meas_ovf), .meas_val_o(meas_val)
  );

  ratio_classifier #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_RATIOS(NUM_RATIOS),
    .BASE(BASE), .TOL(TOL)
  ) u_cls (
    .clk(clk), .rst(rst), .meas_vld_i(meas_vld), .meas_ovf_i(meas_ovf),
    .meas_val_i(meas_val), .cls_vld_o(cls_vld), .cls_ok_o(cls_ok),
    .cls_code_o(cls_code)
  );

  lock_ctrl #(.CODE_W(CODE_W)) u_lock (
    .clk(clk), .rst(rst), .cls_vld_i(cls_vld), .cls_ok_i(cls_ok),
    .cls_code_i(cls_code), .mute_o(mute_o), .shutdown_o(shutdown_o),
    .ratio_o(ratio_int)
  );

  assign ratio_o = 3'(ratio_int);
endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic       mute_o,
  input logic       shutdown_o,
  input logic [2:0] ratio_o,
  input logic       cls_vld
);
  // R4
  shut_implies_mute_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> mute_o);

  // R2
  ratio_code_range_chk: assert property (@(posedge clk) disable iff (rst)
    ratio_o <= 3'd5);

  // R6
  ratio_hold_muted_chk: assert property (@(posedge clk) disable iff (rst)
    (mute_o && $past(mute_o)) |-> $stable(ratio_o));

  // R5
  unmute_needs_result_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mute_o) |-> $past(cls_vld));

  // R5
  shut_release_with_mute_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(shutdown_o) |-> $fell(mute_o));
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
  .clk(clk), .rst(rst), .mute_o(mute_o), .shutdown_o(shutdown_o),
  .ratio_o(ratio_o), .cls_vld(cls_vld)
);

// File: tb/mclk_ratio_detect_bench.sv
module mclk_ratio_detect_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync_in = 1'b0;
  logic       mute_o, shutdown_o;
  logic [2:0] ratio_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference model state
  bit m_armed  = 1'b0;
  bit m_mute   = 1'b1;
  bit m_shut   = 1'b1;
  int m_ratio  = 0;
  int m_cand   = 0;
  bit m_streak = 1'b0;
  int prev_len = 0;

  always #5 clk = ~clk;

  mclk_ratio_detect u_mclk_ratio_detect (
    .clk(clk), .rst(rst), .fsync_in(fsync_in),
    .mute_o(mute_o), .shutdown_o(shutdown_o), .ratio_o(ratio_o)
  );

  function automatic int nom(input int i);
    int t[6] = '{128, 192, 256, 384, 512, 768};
    return t[i];
  endfunction

  function automatic int classify(input int p);
    for (int k = 0; k < 6; k++) begin
      if (p >= nom(k) - 32 && p <= nom(k) + 32) return k;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input int len);
    int c;
    if (!m_armed) begin
      m_armed = 1'b1;
    end else if (len > 801) begin
      m_mute = 1'b1; m_shut = 1'b1; m_streak = 1'b0;
    end else begin
      c = classify(len);
      if (c < 0) begin
        m_mute = 1'b1; m_shut = 1'b1; m_streak = 1'b0;
      end else if (m_streak && c == m_cand) begin
        m_mute = 1'b0; m_shut = 1'b0; m_ratio = c;
      end else begin
        m_mute = 1'b1; m_cand = c; m_streak = 1'b1;
      end
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " mute"}, int'(mute_o), int'(m_mute));
    chk({req, " shutdown"}, int'(shutdown_o), int'(m_shut));
    chk({req, " ratio"}, int'(ratio_o), m_ratio);
  endtask

  // one frame of len cycles starting with a rising edge; checks the result
  // of the frame that this edge closes
  task automatic run_frame(input int len, input string req);
    model_edge(prev_len);
    @(negedge clk);
    fsync_in = 1'b1;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == len / 2) fsync_in = 1'b0;
      if (i == 8) check_outputs(req);
      if (i == 820 && len >= 830) begin
        chk("R7 overrun mute", int'(mute_o), 1);
        chk("R7 overrun shutdown", int'(shutdown_o), 1);
      end
    end
    prev_len = len;
  endtask

  task automatic run_group(input int len, input int reps, input string req);
    for (int r = 0; r < reps; r++) run_frame(len, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    int base_i, reps, len;
    seed = 12345;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_outputs("R1 reset");

    // R1/R5: first edge arms, first measure only nominates
    run_frame(256, "R1 arm");
    run_frame(256, "R5 first");
    run_frame(256, "R5 confirm");
    run_frame(256, "R2 256");

    // R2 boundaries and R4 gaps
    run_group(96, 3, "R2 96");
    run_group(95, 2, "R4 95");
    run_group(160, 3, "R3 160");
    run_group(224, 3, "R3 224");
    run_group(800, 3, "R2 800");
    run_group(289, 2, "R4 289");
    run_group(352, 3, "R2 352");
    run_group(736, 3, "R2 736");
    run_group(735, 2, "R4 735");
    run_group(480, 3, "R2 480");
    run_group(60, 2, "R4 60");

    // R6: stray period while locked
    run_group(384, 4, "R6 lock");
    run_frame(512, "R6 stray");
    run_frame(384, "R6 renominate");
    run_frame(384, "R6 relock");
    run_frame(384, "R6 held");

    // R7: overrun then re-arm
    run_group(192, 3, "R7 pre");
    run_frame(900, "R7 long");
    run_frame(192, "R7 rearm");
    run_frame(192, "R7 nominate");
    run_frame(192, "R7 confirm");
    run_frame(192, "R7 locked");

    // R5: seeded jittered runs with occasional garbage
    for (int g = 0; g < 40; g++) begin
      base_i = $urandom_range(5, 0);
      reps   = $urandom_range(4, 1);
      for (int r = 0; r < reps; r++) begin
        len = nom(base_i) + $urandom_range(40, 0) - 20;
        run_frame(len, "R5 random");
      end
      if ($urandom_range(3, 0) == 0) run_frame($urandom_range(830, 60), "R4 random");
    end

    run_frame(256, "R5 tail");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule